// File: doc/BRIEF.md
# Configurable Pin Register Cell

This block is the register stage that sits between the core logic and the pad buffer of a single general-purpose pin. It holds an input capture register, an output data register and a drive-enable register. A static mode field decides which of these paths is live: input only, output only, bidirectional, or clock forwarding. The input register runs on the input clock and the two output-side registers run on the output clock. Each side can be registered or bypassed, and each side's capture edge is chosen by a static bit. The outgoing data may be inverted, and an unregistered tap of the pad value is offered for routing to dedicated functions.

The pad-facing side is digital only. The cell produces the drive value, the drive enable and two weak-pull requests, and it receives the sampled pad level. While the configuration-active input is high the pin is released, with a weak pull-up. In user mode an undriven pin asks for a weak pull that is up by default and down when selected.

Top module: `gpio_cell`

## Requirements
- R1: Mode encoding `cfg_mode` is 00 input only, 01 output only, 10 bidirectional, 11 clock forwarding. In the output-only and clock-forwarding modes the input path is inactive, so `core_in` and `core_alt` read 0.
- R2: In input-only and bidirectional modes, `core_in` equals `pad_di` directly when `cfg_in_reg` is 0. When `cfg_in_reg` is 1 it equals the value of `pad_di` captured by the input register: on `in_clk` rising edges when `cfg_in_neg` is 0, on falling edges when it is 1.
- R3: In output-only and bidirectional modes, `pad_do` equals `core_out` XOR `cfg_out_inv` when `cfg_out_reg` is 0. When `cfg_out_reg` is 1 it equals the captured `core_out` XOR `cfg_out_inv`, with capture on `out_clk` rising edges (`cfg_out_neg` 0) or falling edges (`cfg_out_neg` 1).
- R4: In bidirectional mode, `pad_oe` follows `core_oe` with no inversion. The `cfg_out_reg` and `cfg_out_neg` bits and `out_clk` govern it, exactly as they govern the data, and the input side's register choice does not affect it.
- R5: `core_alt` is never registered. It equals `pad_di` in input-only and bidirectional modes when `cfg_in_reg` is 0, and it is 0 whenever `cfg_in_reg` is 1.
- R6: In clock-forwarding mode, `pad_do` equals `out_clk` XOR `cfg_out_inv`, and `pad_oe` is 1.
- R7: While `cfg_active` is 1, `pad_oe`, `pad_do`, `core_in`, `core_alt` and `pad_pd` are 0 and `pad_pu` is 1, whatever the mode.
- R8: In user mode, when `pad_oe` is 0, exactly one pull is requested: `pad_pd` if `cfg_pull_dn` is 1, otherwise `pad_pu`. When `pad_oe` is 1 both pull requests are 0.
- R9: Outside configuration, `pad_oe` is held at 1 in output-only mode and at 0 in input-only mode. In input-only mode `pad_do` is 0.
- R10: While `rst_n` is low at a capture edge, every register clears to 0, so registered outputs read 0 (before inversion).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| in_clk | input | 1 | Clock of the input capture register |
| out_clk | input | 1 | Clock of the output and drive-enable registers; forwarded in clock mode |
| rst_n | input | 1 | Synchronous active-low reset, seen on both clocks |
| cfg_mode | input | 2 | Static mode: 00 input, 01 output, 10 bidirectional, 11 clock forwarding |
| cfg_in_reg | input | 1 | 1 registers the input path |
| cfg_in_neg | input | 1 | 1 captures input on the falling edge of in_clk |
| cfg_out_reg | input | 1 | 1 registers the output data and drive enable |
| cfg_out_neg | input | 1 | 1 captures output side on the falling edge of out_clk |
| cfg_out_inv | input | 1 | Inverts the outgoing data or forwarded clock |
| cfg_pull_dn | input | 1 | Selects weak pull-down instead of pull-up when undriven |
| cfg_active | input | 1 | High while the device is being configured |
| core_out | input | 1 | Data from core to pad |
| core_oe | input | 1 | Drive enable from core (bidirectional mode) |
| core_in | output | 1 | Pad data to core, registered or direct |
| core_alt | output | 1 | Unregistered pad tap for dedicated routing |
| pad_di | input | 1 | Sampled pad level from the buffer |
| pad_do | output | 1 | Drive value to the buffer |
| pad_oe | output | 1 | Drive enable to the buffer |
| pad_pu | output | 1 | Weak pull-up request |
| pad_pd | output | 1 | Weak pull-down request |

## Verification
The bench sweeps every mode together with every combination of capture edge, bypass, inversion, pull choice and configuration state. It then samples the outputs between the four distinct clock events of one trial. As a result, a register wired to the wrong edge or clock shows the new value one event early or late, and a bypass that still registers lags by a full event. An inversion applied to the drive enable or the forwarded clock shows up as a flipped `pad_oe` or a clock of the wrong phase. Released-pin checks catch a cell that still drives, or that pulls the wrong way, during configuration or when undriven, and a tap left active under registering shows a nonzero `core_alt`.

// File: rtl/gpio_cell_pkg.sv
// Shared encodings for the pin register cell.
// Assumes the mode field is static while the pin is in use.
package gpio_cell_pkg;

    // Operating mode of the pin; the cell decodes these exact values.
    typedef enum logic [1:0] {
        MODE_IN     = 2'b00,
        MODE_OUT    = 2'b01,
        MODE_BIDIR  = 2'b10,
        MODE_CLKOUT = 2'b11
    } pin_mode_e;

endpackage

// File: rtl/gpio_edge_reg.sv
// Edge-selectable register: a rising-edge bank and a falling-edge bank capture
// the same data; a static select picks which bank is presented.
// Assumes neg_sel only changes while the result is not being relied on.
module gpio_edge_reg #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         neg_sel,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] q_pos;
    logic [W-1:0] q_neg;

    // Rising-edge capture bank with synchronous clear.
    always_ff @(posedge clk) begin
        if (!rst_n) q_pos <= '0;
        else        q_pos <= d;
    end

    // Falling-edge capture bank with synchronous clear.
    always_ff @(negedge clk) begin
        if (!rst_n) q_neg <= '0;
        else        q_neg <= d;
    end

    // Present the bank chosen by the edge select.
    assign q = neg_sel ? q_neg : q_pos;

endmodule

// File: rtl/gpio_in_path.sv
// Input side: optional capture of the pad level on in_clk, plus an unregistered
// tap that is only offered when the capture stage is bypassed.
// Assumes enable already folds in mode and configuration state.
module gpio_in_path (
    input  logic in_clk,
    input  logic rst_n,
    input  logic enable,
    input  logic reg_en,
    input  logic neg_sel,
    input  logic pad_di,
    output logic core_in,
    output logic core_alt
);

    logic in_q;

    gpio_edge_reg #(.W(1)) u_in_reg (
        .clk     (in_clk),
        .rst_n   (rst_n),
        .neg_sel (neg_sel),
        .d       (pad_di),
        .q       (in_q)
    );

    // Choose registered or direct pad value, gated by path activity.
    always_comb begin
        core_in  = 1'b0;
        core_alt = 1'b0;
        if (enable) begin
            core_in  = reg_en ? in_q : pad_di;
            core_alt = reg_en ? 1'b0 : pad_di;
        end
    end

    // R5: the tap is silent whenever the capture stage is in use.
    AST_ALT_SILENT: assert property (@(posedge in_clk) disable iff (!rst_n)
        reg_en |-> !core_alt); // R5

endmodule

// File: rtl/gpio_out_path.sv
// Output side: data and drive enable share one edge-selectable register on
// out_clk; inversion acts on the data only, after the register.
// Assumes the bypass and edge bits are static during use.
module gpio_out_path (
    input  logic out_clk,
    input  logic rst_n,
    input  logic reg_en,
    input  logic neg_sel,
    input  logic inv,
    input  logic core_out,
    input  logic core_oe,
    output logic path_do,
    output logic path_oe
);

    localparam int LANES = 2;

    logic [LANES-1:0] d_bus;
    logic [LANES-1:0] q_bus;
    logic [LANES-1:0] sel_bus;

    assign d_bus = {core_oe, core_out};

    gpio_edge_reg #(.W(LANES)) u_out_reg (
        .clk     (out_clk),
        .rst_n   (rst_n),
        .neg_sel (neg_sel),
        .d       (d_bus),
        .q       (q_bus)
    );

    // Bypass select shared by data and enable lanes.
    assign sel_bus = reg_en ? q_bus : d_bus;

    // Inversion applies to the data lane only.
    assign path_do = sel_bus[0] ^ inv;
    assign path_oe = sel_bus[1];

endmodule

// File: rtl/gpio_cell.sv
// Pin register cell: decodes the mode, steers the input and output paths,
// forwards out_clk in clock mode and resolves the pull requests.
// Assumes configuration inputs are static apart from cfg_active.
module gpio_cell
    import gpio_cell_pkg::*;
(
    input  logic       in_clk,
    input  logic       out_clk,
    input  logic       rst_n,
    input  logic [1:0] cfg_mode,
    input  logic       cfg_in_reg,
    input  logic       cfg_in_neg,
    input  logic       cfg_out_reg,
    input  logic       cfg_out_neg,
    input  logic       cfg_out_inv,
    input  logic       cfg_pull_dn,
    input  logic       cfg_active,
    input  logic       core_out,
    input  logic       core_oe,
    output logic       core_in,
    output logic       core_alt,
    input  logic       pad_di,
    output logic       pad_do,
    output logic       pad_oe,
    output logic       pad_pu,
    output logic       pad_pd
);

    pin_mode_e mode;
    logic      in_en;
    logic      path_do;
    logic      path_oe;
    logic      cfg_sig_stable_ref;

    assign mode  = pin_mode_e'(cfg_mode);
    assign in_en = !cfg_active && (mode == MODE_IN || mode == MODE_BIDIR);
    assign cfg_sig_stable_ref = 1'b1;

    gpio_in_path u_in_path (
        .in_clk   (in_clk),
        .rst_n    (rst_n),
        .enable   (in_en),
        .reg_en   (cfg_in_reg),
        .neg_sel  (cfg_in_neg),
        .pad_di   (pad_di),
        .core_in  (core_in),
        .core_alt (core_alt)
    );

    gpio_out_path u_out_path (
        .out_clk  (out_clk),
        .rst_n    (rst_n),
        .reg_en   (cfg_out_reg),
        .neg_sel  (cfg_out_neg),
        .inv      (cfg_out_inv),
        .core_out (core_out),
        .core_oe  (core_oe),
        .path_do  (path_do),
        .path_oe  (path_oe)
    );

    // Steer drive value and enable by mode; release the pin while configuring.
    always_comb begin
        pad_do = 1'b0;
        pad_oe = 1'b0;
        if (!cfg_active) begin
            unique case (mode)
                MODE_IN:     begin pad_do = 1'b0;                  pad_oe = 1'b0;    end
                MODE_OUT:    begin pad_do = path_do;               pad_oe = 1'b1;    end
                MODE_BIDIR:  begin pad_do = path_do;               pad_oe = path_oe; end
                MODE_CLKOUT: begin pad_do = out_clk ^ cfg_out_inv; pad_oe = 1'b1;    end
                default:     begin pad_do = 1'b0;                  pad_oe = 1'b0;    end
            endcase
        end
    end

    // Weak pull request for an undriven pin; pull-up forced while configuring.
    always_comb begin
        pad_pu = 1'b0;
        pad_pd = 1'b0;
        if (cfg_active) begin
            pad_pu = 1'b1;
        end else if (!pad_oe) begin
            pad_pu = !cfg_pull_dn;
            pad_pd = cfg_pull_dn;
        end
    end

    AST_CFG_RELEASED: assert property (@(posedge in_clk) disable iff (!rst_n)
        cfg_active |-> (!pad_oe && pad_pu && !pad_pd && !core_in)); // R7

    AST_PULL_EXCLUSIVE: assert property (@(posedge in_clk) disable iff (!rst_n)
        !(pad_pu && pad_pd) && !(pad_oe && (pad_pu || pad_pd))); // R8

    AST_IN_MODE_UNDRIVEN: assert property (@(posedge in_clk) disable iff (!rst_n)
        (mode == MODE_IN) |-> !pad_oe); // R9

    AST_OUT_MODE_DRIVEN: assert property (@(posedge in_clk) disable iff (!rst_n)
        (mode == MODE_OUT && !cfg_active) |-> pad_oe); // R9

    AST_NO_INPUT_IN_OUT: assert property (@(posedge in_clk) disable iff (!rst_n)
        (mode == MODE_OUT || mode == MODE_CLKOUT) |-> (!core_in && !core_alt)); // R1

    AST_OUT_RISE_CAPTURE: assert property (@(posedge out_clk) disable iff (!rst_n)
        (mode == MODE_OUT && cfg_out_reg && !cfg_out_neg && !cfg_active)
        |=> (!$stable({cfg_mode, cfg_out_reg, cfg_out_neg, cfg_out_inv, cfg_active})
             || pad_do == ($past(core_out) ^ cfg_out_inv))); // R3

    AST_IN_FALL_CAPTURE: assert property (@(negedge in_clk) disable iff (!rst_n)
        (in_en && cfg_in_reg && cfg_in_neg)
        |=> (!$stable({cfg_mode, cfg_in_reg, cfg_in_neg, cfg_active})
             || core_in == $past(pad_di))); // R2

    AST_REF_TIE: assert property (@(posedge in_clk) disable iff (!rst_n)
        cfg_sig_stable_ref |-> (mode != MODE_CLKOUT || cfg_active || pad_oe)); // R6

endmodule

// File: tb/gpio_cell_bench.sv
`timescale 1ns/1ps
module gpio_cell_bench;

    typedef struct packed {
        logic [1:0] mode;
        logic       in_reg;
        logic       in_neg;
        logic       out_reg;
        logic       out_neg;
        logic       inv;
        logic       pull_dn;
        logic       active;
    } cfg_t;

    logic in_clk = 1'b0;
    logic out_clk = 1'b0;
    logic rst_n = 1'b0;
    cfg_t cfg = '0;
    logic core_out = 1'b0, core_oe = 1'b0, pad_di = 1'b0;
    logic core_in, core_alt, pad_do, pad_oe, pad_pu, pad_pd;

    int n_tests = 0;
    int n_fail = 0;
    bit done = 1'b0;
    logic old_out = 1'b0, old_oe = 1'b0, old_pad = 1'b0;

    // 200 MHz input clock; output clock same rate, a quarter period later.
    always #2.5 in_clk = ~in_clk;
    initial begin
        #3.75;
        forever begin
            out_clk = ~out_clk;
            #2.5;
        end
    end

    gpio_cell u_gpio_cell (
        .in_clk(in_clk), .out_clk(out_clk), .rst_n(rst_n),
        .cfg_mode(cfg.mode), .cfg_in_reg(cfg.in_reg), .cfg_in_neg(cfg.in_neg),
        .cfg_out_reg(cfg.out_reg), .cfg_out_neg(cfg.out_neg),
        .cfg_out_inv(cfg.inv), .cfg_pull_dn(cfg.pull_dn), .cfg_active(cfg.active),
        .core_out(core_out), .core_oe(core_oe), .core_in(core_in),
        .core_alt(core_alt), .pad_di(pad_di), .pad_do(pad_do),
        .pad_oe(pad_oe), .pad_pu(pad_pu), .pad_pd(pad_pd)
    );

    task automatic chk(input string tag, input string what, input logic got, input logic exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %b expected %b (t=%0t)", tag, what, got, exp, $time);
        end
    endtask

    // Value seen after a capture stage: new once its edge has passed in this trial.
    function automatic logic pick(input logic seen, input logic nv, input logic ov);
        return seen ? nv : ov;
    endfunction

    // Expected outputs {core_in, alt, do, oe, pu, pd} from the requirements.
    function automatic logic [5:0] expect_out(input cfg_t c, input int step,
                                              input logic ocl,
                                              input logic n_o, n_e, n_p,
                                              input logic o_o, o_e, o_p);
        logic in_act, ci, al, dv, ov, ev, pu, pd, in_seen, out_seen;
        in_act   = (c.mode == 2'b00 || c.mode == 2'b10) && !c.active;
        in_seen  = c.in_neg ? (step >= 3) : (step >= 5);
        out_seen = c.out_neg ? (step >= 4) : (step >= 2);
        ci = !in_act ? 1'b0 : (c.in_reg ? pick(in_seen, n_p, o_p) : n_p);
        al = (in_act && !c.in_reg) ? n_p : 1'b0;
        ov = (c.out_reg ? pick(out_seen, n_o, o_o) : n_o) ^ c.inv;
        ev = c.out_reg ? pick(out_seen, n_e, o_e) : n_e;
        dv = 1'b0;
        if (!c.active) begin
            case (c.mode)
                2'b00: begin dv = 1'b0;          ev = 1'b0; end
                2'b01: begin dv = ov;            ev = 1'b1; end
                2'b10: begin dv = ov;                       end
                default: begin dv = ocl ^ c.inv; ev = 1'b1; end
            endcase
        end else begin
            ev = 1'b0;
        end
        pu = c.active ? 1'b1 : (!ev && !c.pull_dn);
        pd = c.active ? 1'b0 : (!ev && c.pull_dn);
        return {ci, al, dv, ev, pu, pd};
    endfunction

    task automatic compare(input cfg_t c, input int step, input logic n_o, n_e, n_p);
        logic [5:0] e;
        e = expect_out(c, step, out_clk, n_o, n_e, n_p, old_out, old_oe, old_pad);
        chk(c.active ? "R7" : ((c.mode == 2'b01 || c.mode == 2'b11) ? "R1" : "R2"),
            "core_in", core_in, e[5]);
        chk(c.active ? "R7" : "R5", "core_alt", core_alt, e[4]);
        chk(c.active ? "R7" : (c.mode == 2'b11 ? "R6" : (c.mode == 2'b00 ? "R9" : "R3")),
            "pad_do", pad_do, e[3]);
        chk(c.active ? "R7" : (c.mode == 2'b10 ? "R4" : "R9"), "pad_oe", pad_oe, e[2]);
        chk(c.active ? "R7" : "R8", "pad_pu", pad_pu, e[1]);
        chk(c.active ? "R7" : "R8", "pad_pd", pad_pd, e[0]);
    endtask

    // One trial: new settings just after an in_clk rise, checked between each clock event.
    task automatic run_trial(input cfg_t c, input logic n_o, n_e, n_p);
        @(posedge in_clk);
        #0.6;
        cfg = c; core_out = n_o; core_oe = n_e; pad_di = n_p;
        #0.1;  compare(c, 1, n_o, n_e, n_p);   // before any edge
        #1.15; compare(c, 2, n_o, n_e, n_p);   // after out_clk rise
        #1.25; compare(c, 3, n_o, n_e, n_p);   // after in_clk fall
        #1.25; compare(c, 4, n_o, n_e, n_p);   // after out_clk fall
        #1.25; compare(c, 5, n_o, n_e, n_p);   // after in_clk rise
        old_out = n_o; old_oe = n_e; old_pad = n_p;
    endtask

    initial begin
        #100000;
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        cfg_t c;
        void'($urandom(32'd4711));
        // R10: registered paths read 0 while reset is held, even with ones driven.
        cfg = '{mode: 2'b10, in_reg: 1'b1, in_neg: 1'b0, out_reg: 1'b1,
                out_neg: 1'b0, inv: 1'b0, pull_dn: 1'b0, active: 1'b0};
        core_out = 1'b1; core_oe = 1'b1; pad_di = 1'b1;
        repeat (4) @(posedge in_clk);
        #0.6;
        chk("R10", "core_in in reset", core_in, 1'b0);
        chk("R10", "pad_do in reset", pad_do, 1'b0);
        chk("R10", "pad_oe in reset", pad_oe, 1'b0);
        chk("R10", "pad_pu in reset", pad_pu, 1'b1);
        cfg.in_neg = 1'b1; cfg.out_neg = 1'b1;
        #0.1;
        chk("R10", "core_in fall bank in reset", core_in, 1'b0);
        chk("R10", "pad_do fall bank in reset", pad_do, 1'b0);
        core_out = 1'b0; core_oe = 1'b0; pad_di = 1'b0;
        repeat (2) @(posedge in_clk);
        #0.6;
        rst_n = 1'b1;

        // Every combination of mode, edges, bypass, inversion, pull and config state.
        for (int k = 0; k < 512; k++) begin
            c = cfg_t'(k[8:0]);
            run_trial(c, ~old_out, 1'($urandom), ~old_pad);
        end
        // Random settings and data.
        for (int k = 0; k < 300; k++) begin
            c = cfg_t'($urandom);
            run_trial(c, 1'($urandom), 1'($urandom), 1'($urandom));
        end
        // Directed: bidirectional with registered output but direct input (R4).
        c = '{mode: 2'b10, in_reg: 1'b0, in_neg: 1'b0, out_reg: 1'b1,
              out_neg: 1'b1, inv: 1'b1, pull_dn: 1'b1, active: 1'b0};
        run_trial(c, 1'b1, ~old_oe, 1'b1);
        run_trial(c, 1'b0, ~old_oe, 1'b0);
        // Directed: clock forwarding with and without inversion (R6).
        c = '{mode: 2'b11, in_reg: 1'b0, in_neg: 1'b0, out_reg: 1'b0,
              out_neg: 1'b0, inv: 1'b0, pull_dn: 1'b0, active: 1'b0};
        run_trial(c, 1'b0, 1'b0, 1'b1);
        c.inv = 1'b1;
        run_trial(c, 1'b1, 1'b0, 1'b1);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule